// File: doc/BRIEF.md
# Dual-Port Video Memory with Serial Row Streamer

This block models a dual-ported video memory built around a small row/column array. A random-access port reads and writes single elements by row and column address, one operation per clock. A second, read-only serial port exists only to feed a display. On a row-transfer command, issued alongside the random-access port, one whole row of the array is copied into an internal shift register in a single cycle. Each later single-cycle shift enable moves the serial output to the next column of that copy, in ascending column order, wrapping after the last column.

The two ports work concurrently. While the serial port is streaming, the random-access port keeps reading and writing the array, including the row that was transferred. Those writes reach the array but not the shift register, which only changes on the next transfer. The transfer command carries a start column that loads the serial pointer.

The serial side is a two-state machine. `SER_EMPTY` is the reset state: no row has been captured and the serial output reads zero. The transition `LOAD` (transfer request seen) moves it to `SER_ARMED`, where the output presents the shift register element under the pointer. In `SER_ARMED` a transfer request takes the transition `RELOAD`, which recaptures a row and stays in `SER_ARMED`. No transition leads back to `SER_EMPTY` except reset.

Top module: `vid_dualport_mem`

## Requirements
- R1: After reset `ser_valid` is 0, `ser_data` is 0 and `ra_rdata` is 0.
- R2: A write (`ra_en`=1, `ra_we`=1) stores `ra_wdata` at (`ra_row`, `ra_col`). A read (`ra_en`=1, `ra_we`=0) presents the stored element on `ra_rdata` after the next rising edge. `ra_rdata` holds its value in cycles with no read.
- R3: A transfer (`xfer_req`=1) copies every column of row `xfer_row` into the shift register and loads the serial pointer with `xfer_col`. After that edge, `ser_valid` is 1 and `ser_data` shows the captured element at column `xfer_col`.
- R4: Each cycle with `sh_en`=1 (and no transfer) moves `ser_data` to the next column in ascending order. Cycles with `sh_en`=0 leave `ser_data` unchanged.
- R5: A shift from the last column (COLS-1) wraps the pointer to column 0.
- R6: A write to the array after a transfer, including a write to the transferred row, does not change the shift register until the next transfer.
- R7: Random-access reads and writes give the same results while shift enables are being applied as they do when the serial port is idle.
- R8: A transfer and a write to the same row in the same cycle are both honoured. The transfer captures the row contents from before the write, and the write lands in the array.
- R9: A transfer and a shift enable in the same cycle: the transfer wins, and the pointer takes `xfer_col`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ra_en | input | 1 | Random-access operation request |
| ra_we | input | 1 | 1 = write, 0 = read |
| ra_row | input | 4 | Random-access row address |
| ra_col | input | 4 | Random-access column address |
| ra_wdata | input | 8 | Write data |
| ra_rdata | output | 8 | Registered read data |
| xfer_req | input | 1 | Row-transfer command |
| xfer_row | input | 4 | Row to capture |
| xfer_col | input | 4 | Start column for the serial pointer |
| sh_en | input | 1 | Single-cycle shift enable |
| ser_valid | output | 1 | A row has been captured |
| ser_data | output | 8 | Serial output element |

## Verification
Read data is due one edge after the read request. The transfer result and every shift step show on the serial output directly after the edge that samples the command, because that output is taken from registers without a further stage. The bench drives every input on the falling edge and samples on the next falling edge, exactly one rising edge later. This makes each check land in the cycle the result is due. Streaming runs cover every row, each with a different start column and more pulses than there are columns so that the wrap is included, while writes go to the captured row at the same time. Expected values come from a bench-side model of the array and from a snapshot taken at each transfer.

// File: rtl/vdm_pkg.sv
package vdm_pkg;
    typedef enum logic [0:0] {
        SER_EMPTY = 1'b0,
        SER_ARMED = 1'b1
    } ser_state_t;
endpackage

// File: rtl/vdm_array.sv
module vdm_array #(
    parameter int ROWS = 16,
    parameter int COLS = 16,
    parameter int DW   = 8,
    localparam int RAW = $clog2(ROWS),
    localparam int CAW = $clog2(COLS)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     ra_en,
    input  logic                     ra_we,
    input  logic [RAW-1:0]           ra_row,
    input  logic [CAW-1:0]           ra_col,
    input  logic [DW-1:0]            ra_wdata,
    output logic [DW-1:0]            ra_rdata,
    input  logic [RAW-1:0]           tap_row,
    output logic [COLS-1:0][DW-1:0]  tap_bus
);
    logic [DW-1:0] mem [ROWS][COLS];
    logic          do_wr;
    logic          do_rd;

    assign do_wr = ra_en && ra_we;
    assign do_rd = ra_en && !ra_we;

    // storage write: no reset on the array itself
    always_ff @(posedge clk) begin
        if (do_wr) begin
            mem[ra_row][ra_col] <= ra_wdata;
        end
    end

    // registered read port
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ra_rdata <= '0;
        end else if (do_rd) begin
            ra_rdata <= mem[ra_row][ra_col];
        end
    end

    // whole-row tap for the transfer path (pre-write contents)
    for (genvar c = 0; c < COLS; c++) begin : g_tap
        assign tap_bus[c] = mem[tap_row][c];
    end

    // R2
    rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !do_rd |=> $stable(ra_rdata));
endmodule

// File: rtl/vdm_serial.sv
module vdm_serial
    import vdm_pkg::*;
#(
    parameter int COLS = 16,
    parameter int DW   = 8,
    localparam int CAW = $clog2(COLS)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     xfer_req,
    input  logic [CAW-1:0]           xfer_col,
    input  logic [COLS-1:0][DW-1:0]  row_in,
    input  logic                     sh_en,
    output logic                     ser_valid,
    output logic [DW-1:0]            ser_data
);
    localparam logic [CAW-1:0] LAST_COL = CAW'(COLS - 1);

    ser_state_t               state_q;
    ser_state_t               state_d;
    logic [COLS-1:0][DW-1:0]  sreg_q;
    logic [CAW-1:0]           ptr_q;
    logic                     step;

    // next-state decode: LOAD from empty, RELOAD while armed
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SER_EMPTY: if (xfer_req) state_d = SER_ARMED;
            SER_ARMED: state_d = SER_ARMED;
            default:   state_d = SER_EMPTY;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SER_EMPTY;
        end else begin
            state_q <= state_d;
        end
    end

    assign step = (state_q == SER_ARMED) && sh_en && !xfer_req;

    // shift register and pointer datapath
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sreg_q <= '0;
            ptr_q  <= '0;
        end else if (xfer_req) begin
            sreg_q <= row_in;
            ptr_q  <= xfer_col;
        end else if (step) begin
            ptr_q  <= (ptr_q == LAST_COL) ? '0 : ptr_q + CAW'(1);
        end
    end

    // output process
    always_comb begin
        ser_valid = 1'b0;
        ser_data  = '0;
        unique case (state_q)
            SER_EMPTY: begin
                ser_valid = 1'b0;
                ser_data  = '0;
            end
            SER_ARMED: begin
                ser_valid = 1'b1;
                ser_data  = sreg_q[ptr_q];
            end
            default: begin
                ser_valid = 1'b0;
                ser_data  = '0;
            end
        endcase
    end

    // R3
    xfer_ptr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_req |=> (ptr_q == $past(xfer_col)) && ser_valid);
    // R4
    step_adv_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step && ptr_q != LAST_COL) |=> ptr_q == $past(ptr_q) + CAW'(1));
    // R4
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!xfer_req && !sh_en) |=> $stable(ptr_q));
    // R5
    wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step && ptr_q == LAST_COL) |=> ptr_q == '0);
    // R6
    sreg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !xfer_req |=> $stable(sreg_q));
    // R1
    empty_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ser_valid |-> ser_data == '0);
endmodule

// File: rtl/vid_dualport_mem.sv
module vid_dualport_mem #(
    parameter int ROWS = 16,
    parameter int COLS = 16,
    parameter int DW   = 8,
    localparam int RAW = $clog2(ROWS),
    localparam int CAW = $clog2(COLS)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           ra_en,
    input  logic           ra_we,
    input  logic [RAW-1:0] ra_row,
    input  logic [CAW-1:0] ra_col,
    input  logic [DW-1:0]  ra_wdata,
    output logic [DW-1:0]  ra_rdata,
    input  logic           xfer_req,
    input  logic [RAW-1:0] xfer_row,
    input  logic [CAW-1:0] xfer_col,
    input  logic           sh_en,
    output logic           ser_valid,
    output logic [DW-1:0]  ser_data
);
    logic [COLS-1:0][DW-1:0] row_bus;

    vdm_array #(.ROWS(ROWS), .COLS(COLS), .DW(DW)) u_array (
        .clk      (clk),
        .rst_n    (rst_n),
        .ra_en    (ra_en),
        .ra_we    (ra_we),
        .ra_row   (ra_row),
        .ra_col   (ra_col),
        .ra_wdata (ra_wdata),
        .ra_rdata (ra_rdata),
        .tap_row  (xfer_row),
        .tap_bus  (row_bus)
    );

    vdm_serial #(.COLS(COLS), .DW(DW)) u_serial (
        .clk       (clk),
        .rst_n     (rst_n),
        .xfer_req  (xfer_req),
        .xfer_col  (xfer_col),
        .row_in    (row_bus),
        .sh_en     (sh_en),
        .ser_valid (ser_valid),
        .ser_data  (ser_data)
    );
endmodule

// File: tb/tb_vid_dualport_mem.sv
module tb_vid_dualport_mem;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ra_en = 1'b0, ra_we = 1'b0;
    logic [3:0] ra_row = '0, ra_col = '0;
    logic [7:0] ra_wdata = '0;
    logic [7:0] ra_rdata;
    logic       xfer_req = 1'b0;
    logic [3:0] xfer_row = '0, xfer_col = '0;
    logic       sh_en = 1'b0;
    logic       ser_valid;
    logic [7:0] ser_data;

    int n_chk = 0;
    int n_bad = 0;
    logic [7:0] model [16][16];
    logic [7:0] snap  [16];
    logic done = 1'b0;

    always #4 clk = ~clk;

    vid_dualport_mem dut (.*);

    function automatic logic [7:0] pat(input int r, input int c, input int salt);
        return 8'((r * 17 + c * 3 + 1 + salt * 29) & 255);
    endfunction

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic cyc();
        @(negedge clk);
    endtask

    task automatic idle();
        ra_en = 0; ra_we = 0; xfer_req = 0; sh_en = 0;
    endtask

    task automatic wr(input int r, input int c, input logic [7:0] d);
        ra_en = 1; ra_we = 1; ra_row = 4'(r); ra_col = 4'(c); ra_wdata = d;
        model[r][c] = d;
    endtask

    task automatic take_snap(input int r);
        for (int c = 0; c < 16; c++) snap[c] = model[r][c];
    endtask

    initial begin
        for (int i = 0; i < 100000; i++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        cyc(); cyc();
        // R1: reset state
        chk("R1 ser_valid", {7'd0, ser_valid}, 8'd0);
        chk("R1 ser_data", ser_data, 8'd0);
        chk("R1 ra_rdata", ra_rdata, 8'd0);
        rst_n = 1'b1;
        cyc();

        // R2: fill the array, then read every element back
        for (int r = 0; r < 16; r++)
            for (int c = 0; c < 16; c++) begin
                wr(r, c, pat(r, c, 0)); cyc();
            end
        idle();
        cyc();
        // R1: the serial port stays empty after writes alone
        chk("R1 empty after writes", {7'd0, ser_valid}, 8'd0);
        for (int r = 0; r < 16; r++)
            for (int c = 0; c < 16; c++) begin
                ra_en = 1; ra_we = 0; ra_row = 4'(r); ra_col = 4'(c);
                cyc();
                chk("R2 read", ra_rdata, model[r][c]);
            end
        idle(); cyc();
        // R2: rdata holds with no read
        chk("R2 hold", ra_rdata, model[15][15]);

        // streaming runs on every row
        for (int r = 0; r < 16; r++) begin
            int s = (r * 5) % 16;
            // R8: transfer plus write to the same row in one cycle
            take_snap(r);
            xfer_req = 1; xfer_row = 4'(r); xfer_col = 4'(s);
            wr(r, s, pat(r, s, 7));
            cyc();
            idle();
            chk("R3/R8 first element", ser_data, snap[s]);
            chk("R3 valid", {7'd0, ser_valid}, 8'd1);
            // R4: hold without shift
            cyc();
            chk("R4 hold", ser_data, snap[s]);
            // R4/R5/R6/R7: 17 shifts with concurrent array writes and reads
            for (int k = 1; k <= 17; k++) begin
                sh_en = 1;
                if (k % 2 == 1) begin
                    wr(r, (s + k) % 16, pat(r, k, 3));
                    cyc();
                end else begin
                    ra_en = 1; ra_we = 0; ra_row = 4'((r + 3) % 16); ra_col = 4'(k % 16);
                    cyc();
                    chk("R7 read during stream", ra_rdata, model[(r + 3) % 16][k % 16]);
                end
                idle();
                chk(((s + k) % 16 == 0) ? "R5 wrap" : "R4/R6 shift", ser_data, snap[(s + k) % 16]);
            end
            // R7/R8: writes landed in the array
            ra_en = 1; ra_we = 0; ra_row = 4'(r); ra_col = 4'(s);
            cyc();
            chk("R7/R8 write landed", ra_rdata, model[r][s]);
            ra_col = 4'((s + 1) % 16);
            cyc();
            chk("R7 write landed", ra_rdata, model[r][(s + 1) % 16]);
            idle();
        end

        // R9: transfer with shift in the same cycle
        take_snap(9);
        xfer_req = 1; xfer_row = 4'd9; xfer_col = 4'd15; sh_en = 1;
        cyc(); idle();
        chk("R9 transfer wins", ser_data, snap[15]);
        sh_en = 1; cyc(); idle();
        chk("R5 wrap at 15", ser_data, snap[0]);
        // R6: overwrite row 9, shift register unchanged
        for (int c = 0; c < 16; c++) begin
            wr(9, c, 8'hEE); cyc();
        end
        idle();
        sh_en = 1; cyc(); idle();
        chk("R6 isolated", ser_data, snap[1]);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule